// File: doc/BRIEF.md
# Channel-interleaved sample transposer

This block sits behind the byte stream of a logic-capture front end. In that stream each 16-bit word carries a burst of 16 consecutive samples from one channel. The words cycle through the enabled channels in turn. The block rebuilds ordinary parallel samples from them, one output word per sample instant, with one bit per channel. A per-slot mask table chooses which output bit, or bits, each slot's samples land on.

Bytes arrive with a valid/ready handshake and a transfer-end marker. Each pair of bytes forms one word. The slot counter and the partial accumulation persist from one transfer to the next. When the last configured slot has been folded in, the 16 rebuilt samples leave on a valid/ready output stream. Input is stalled while they drain. A transfer that ends on a lone byte drops that byte and raises a sticky error. A synchronous clear returns the block to a clean start.

Top module: `sample_transposer`

## Requirements
- R1: A word is formed from two accepted bytes: the first byte is bits 7:0 and the second is bits 15:8.
- R2: In a word, bit 15 is the earliest sample of the burst (output sample 0) and bit 0 is the latest (output sample 15).
- R3: For every set bit of a word, the mask of the current slot (bits [16*s+15:16*s] of `mask_tab_i` for slot s) is ORed into the matching output sample. Overlapping masks from several slots combine by OR.
- R4: The slot counter advances once per word and wraps to 0 after slot `num_slots_i`-1. At that wrap exactly 16 samples are output, from sample 0 to sample 15.
- R5: The accumulation is empty after a round completes, so the next round depends only on its own words.
- R6: If a transfer ends (`byte_last_i` on an accepted byte) with no byte already held, that byte is discarded and `err_odd_o` rises. It stays high until clear. The slot count is unaffected.
- R7: A transfer ending on a complete word leaves the slot counter and the accumulation intact for the next transfer.
- R8: `byte_ready_o` is low while output samples are pending. A sample offered while `sample_ready_i` is low holds both value and valid.
- R9: `clear_i` discards the held half-word, the slot position, the accumulation, pending output and the error flag.
- R10: After reset, `sample_valid_o` and `err_odd_o` are low and `byte_ready_o` is high.
- R11: Channel counts from 1 up to 16 are supported. Configuration is changed only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all stream state |
| num_slots_i | input | 5 | Number of interleaved channel slots, 1 to 16 |
| mask_tab_i | input | 256 | Sixteen 16-bit output masks, slot s at bits 16*s+15:16*s |
| byte_i | input | 8 | Input stream byte |
| byte_valid_i | input | 1 | Input byte valid |
| byte_last_i | input | 1 | Marks the last byte of a transfer |
| byte_ready_o | output | 1 | Input byte accepted when high with valid |
| sample_o | output | 16 | Rebuilt parallel sample |
| sample_valid_o | output | 1 | Output sample valid |
| sample_ready_i | input | 1 | Consumer ready for a sample |
| err_odd_o | output | 1 | Sticky odd-length transfer error |

## Verification
The hardest case to reach is a round-completing word that is still being folded in while the next low byte is already accepted, with the drain then backpressured. This is the only moment the input and the output side overlap. The stimulus gets there by sending bytes back to back across round boundaries while a stuttering ready pattern on the output holds samples. Odd transfers in mid-round and a clear issued with a half word held check that the discarded bytes leave no trace in the later rounds, which are compared against a bench-side model of the accumulation.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned TP_BYTE_W = 8;

  function automatic int unsigned tp_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tp_packer.sv
module tp_packer #(
  parameter  int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic              byte_last_i,
  input  logic              block_i,
  output logic              byte_ready_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              err_odd_o
);
  logic              have_lo_q;
  logic [BYTE_W-1:0] lo_q;
  logic [WORD_W-1:0] word_q;
  logic              vld_q;
  logic              err_q;
  logic              take;

  assign byte_ready_o = !block_i;
  assign take         = byte_valid_i && !block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_lo_q <= 1'b0;
      lo_q      <= '0;
      word_q    <= '0;
      vld_q     <= 1'b0;
      err_q     <= 1'b0;
    end else if (clear_i) begin
      have_lo_q <= 1'b0;
      vld_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (take) begin
        if (!have_lo_q) begin
          // a lone byte closing a transfer is dropped
          if (byte_last_i) err_q <= 1'b1;
          else begin
            lo_q      <= byte_i;
            have_lo_q <= 1'b1;
          end
        end else begin
          word_q    <= {byte_i, lo_q};
          vld_q     <= 1'b1;
          have_lo_q <= 1'b0;
        end
      end
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
  assign err_odd_o  = err_q;
endmodule

// File: rtl/tp_accum.sv
module tp_accum #(
  parameter  int unsigned WORD_W    = 16,
  parameter  int unsigned MAX_SLOTS = 16,
  localparam int unsigned CNT_W     = $clog2(MAX_SLOTS + 1),
  localparam int unsigned SLOT_W    = tp_pkg::tp_idx_w(MAX_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        flush_i,
  input  logic [CNT_W-1:0]            num_slots_i,
  input  logic [MAX_SLOTS*WORD_W-1:0] mask_tab_i,
  input  logic [WORD_W-1:0]           word_i,
  input  logic                        word_vld_i,
  output logic [WORD_W*WORD_W-1:0]    acc_o,
  output logic                        round_done_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] last_slot;
  logic [WORD_W-1:0] cur_mask;

  assign last_slot    = SLOT_W'(num_slots_i - CNT_W'(1));
  assign cur_mask     = mask_tab_i[slot_q*WORD_W +: WORD_W];
  assign round_done_o = word_vld_i && (slot_q == last_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                slot_q <= '0;
    else if (clear_i)           slot_q <= '0;
    else if (round_done_o)      slot_q <= '0;
    else if (word_vld_i)        slot_q <= slot_q + SLOT_W'(1);
  end

  // row i holds output sample i; word bit WORD_W-1-i feeds it
  for (genvar i = 0; i < WORD_W; i++) begin : g_row
    logic [WORD_W-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                row_q <= '0;
      else if (clear_i || flush_i)                row_q <= '0;
      else if (word_vld_i && word_i[WORD_W-1-i])  row_q <= row_q | cur_mask;
    end
    assign acc_o[i*WORD_W +: WORD_W] = row_q;
  end
endmodule

// File: rtl/tp_drain.sv
module tp_drain #(
  parameter  int unsigned WORD_W = 16,
  localparam int unsigned IDX_W  = tp_pkg::tp_idx_w(WORD_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     start_i,
  input  logic [WORD_W*WORD_W-1:0] acc_i,
  input  logic                     ready_i,
  output logic [WORD_W-1:0]        sample_o,
  output logic                     valid_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign done_o = busy_q && ready_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && ready_i) begin
      if (done_o) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign sample_o = acc_i[idx_q*WORD_W +: WORD_W];
  assign valid_o  = busy_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/sample_transposer.sv
module sample_transposer #(
  parameter  int unsigned WORD_W    = 16,
  parameter  int unsigned MAX_SLOTS = 16,
  localparam int unsigned BYTE_W    = WORD_W / 2,
  localparam int unsigned CNT_W     = $clog2(MAX_SLOTS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic [CNT_W-1:0]            num_slots_i,
  input  logic [MAX_SLOTS*WORD_W-1:0] mask_tab_i,
  input  logic [BYTE_W-1:0]           byte_i,
  input  logic                        byte_valid_i,
  input  logic                        byte_last_i,
  output logic                        byte_ready_o,
  output logic [WORD_W-1:0]           sample_o,
  output logic                        sample_valid_o,
  input  logic                        sample_ready_i,
  output logic                        err_odd_o
);
  logic [WORD_W-1:0]        word;
  logic                     word_vld;
  logic [WORD_W*WORD_W-1:0] acc;
  logic                     round_done;
  logic                     drain_busy;
  logic                     drain_done;

  tp_packer #(.BYTE_W(BYTE_W)) u_packer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .byte_i       (byte_i),
    .byte_valid_i (byte_valid_i),
    .byte_last_i  (byte_last_i),
    .block_i      (drain_busy),
    .byte_ready_o (byte_ready_o),
    .word_o       (word),
    .word_vld_o   (word_vld),
    .err_odd_o    (err_odd_o)
  );

  tp_accum #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS)) u_accum (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .flush_i      (drain_done),
    .num_slots_i  (num_slots_i),
    .mask_tab_i   (mask_tab_i),
    .word_i       (word),
    .word_vld_i   (word_vld),
    .acc_o        (acc),
    .round_done_o (round_done)
  );

  tp_drain #(.WORD_W(WORD_W)) u_drain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .start_i  (round_done),
    .acc_i    (acc),
    .ready_i  (sample_ready_i),
    .sample_o (sample_o),
    .valid_o  (sample_valid_o),
    .busy_o   (drain_busy),
    .done_o   (drain_done)
  );
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              byte_valid_i,
  input logic              byte_last_i,
  input logic              byte_ready_o,
  input logic [WORD_W-1:0] sample_o,
  input logic              sample_valid_o,
  input logic              sample_ready_i,
  input logic              err_odd_o
);
  localparam int unsigned CW = $clog2(WORD_W + 1);
  logic [CW-1:0] hs_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 hs_cnt <= '0;
    else if (clear_i)                            hs_cnt <= '0;
    else if (sample_valid_o && sample_ready_i)
      hs_cnt <= (hs_cnt == CW'(WORD_W - 1)) ? '0 : hs_cnt + CW'(1);
  end

  assert_ready_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> !byte_ready_o);

  assert_hold_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && !sample_ready_i && !clear_i) |=> (sample_valid_o && $stable(sample_o)));

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_odd_o && !clear_i) |=> err_odd_o);

  assert_err_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_odd_o) |-> $past(byte_valid_i && byte_ready_o && byte_last_i));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!sample_valid_o && !err_odd_o));

  assert_round_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && sample_ready_i && hs_cnt == CW'(WORD_W - 1) && !clear_i) |=> !sample_valid_o);
endmodule

bind sample_transposer tp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .byte_valid_i   (byte_valid_i),
  .byte_last_i    (byte_last_i),
  .byte_ready_o   (byte_ready_o),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o),
  .sample_ready_i (sample_ready_i),
  .err_odd_o      (err_odd_o)
);

// File: tb/sample_transposer_test.sv
module sample_transposer_test;
  localparam int W  = 16;
  localparam int MS = 16;
  localparam int CW = 5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            clear_i = 1'b0;
  logic [CW-1:0]   num_slots_i = CW'(1);
  logic [MS*W-1:0] mask_tab_i = '0;
  logic [7:0]      byte_i = '0;
  logic            byte_valid_i = 1'b0;
  logic            byte_last_i = 1'b0;
  logic            byte_ready_o;
  logic [W-1:0]    sample_o;
  logic            sample_valid_o;
  logic            sample_ready_i = 1'b1;
  logic            err_odd_o;

  always #10 clk_i = ~clk_i;

  sample_transposer uut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] bexp [W];
  logic [W-1:0] bmask [MS];
  int bslot = 0;
  int bnch  = 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    bslot = 0;
    for (int i = 0; i < W; i++) bexp[i] = '0;
  endtask

  task automatic set_cfg(input int nch);
    bnch = nch;
    num_slots_i = CW'(nch);
    for (int s = 0; s < MS; s++) mask_tab_i[s*W +: W] = bmask[s];
  endtask

  task automatic model_word(input logic [W-1:0] w, input string tag);
    for (int i = 0; i < W; i++)
      if (w[W-1-i]) bexp[i] = bexp[i] | bmask[bslot];
    bslot++;
    if (bslot == bnch) begin
      for (int i = 0; i < W; i++) begin
        exp_q.push_back(bexp[i]);
        tag_q.push_back(tag);
        bexp[i] = '0;
      end
      bslot = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit last);
    bit r;
    @(posedge clk_i); #1;
    byte_i = b; byte_valid_i = 1'b1; byte_last_i = last;
    forever begin
      @(negedge clk_i); r = byte_ready_o;
      @(posedge clk_i);
      if (r) break;
    end
    #1; byte_valid_i = 1'b0; byte_last_i = 1'b0;
  endtask

  task automatic send_word(input logic [W-1:0] w, input bit last, input string tag);
    model_word(w, tag);
    send_byte(w[7:0], 1'b0);
    send_byte(w[15:8], last);
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (exp_q.size() != 0 || sample_valid_o);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic do_clear();
    @(posedge clk_i); #1 clear_i = 1'b1;
    @(posedge clk_i); #1 clear_i = 1'b0;
    model_reset();
  endtask

  function automatic logic [W-1:0] gen(input int k);
    return W'(k * 16'h3A5B) ^ 16'hC01D;
  endfunction

  // stuttering consumer
  int rcnt = 0;
  always @(posedge clk_i) begin
    #1;
    rcnt++;
    sample_ready_i = ((rcnt % 7) != 3) && ((rcnt % 11) != 5);
  end

  // monitor / scoreboard
  bit           hold_prev = 1'b0;
  logic [W-1:0] prev_s = '0;
  always @(negedge clk_i) begin
    if (rst_ni && sample_valid_o) begin
      check(!byte_ready_o, "R8 input stalled during drain", 32'(byte_ready_o), 32'd0);
      if (hold_prev) check(sample_o == prev_s, "R8 sample held", 32'(sample_o), 32'(prev_s));
      if (sample_ready_i) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected sample", 32'(sample_o), 32'hFFFF_FFFF);
        else begin
          logic [W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(sample_o == e, t, 32'(sample_o), 32'(e));
        end
      end
    end
    hold_prev = rst_ni && sample_valid_o && !sample_ready_i;
    prev_s    = sample_o;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < MS; s++) bmask[s] = '0;
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(!sample_valid_o, "R10 reset valid low", 32'(sample_valid_o), 0);
    check(!err_odd_o, "R10 reset error low", 32'(err_odd_o), 0);
    check(byte_ready_o, "R10 reset ready high", 32'(byte_ready_o), 1);

    // R1 R2 R4 R5: four slots, one bit per slot, two rounds back to back
    for (int s = 0; s < MS; s++) bmask[s] = W'(1) << s;
    set_cfg(4);
    send_word(16'h8001, 1'b0, "R1 R2 R4 order");
    send_word(16'h00FF, 1'b0, "R1 R2 R4 order");
    send_word(16'hF0F0, 1'b0, "R1 R2 R4 order");
    send_word(16'h1234, 1'b0, "R1 R2 R4 order");
    for (int k = 0; k < 4; k++) send_word(gen(k), 1'b0, "R5 next round clean");
    wait_idle();

    // R3: overlapping masks
    bmask[0] = 16'h0003; bmask[1] = 16'h0101; bmask[2] = 16'h8000;
    set_cfg(3);
    for (int k = 0; k < 6; k++) send_word(gen(k + 10), 1'b0, "R3 mask OR");
    wait_idle();

    // R7: transfer ends mid-round on an even boundary
    for (int s = 0; s < MS; s++) bmask[s] = W'(1) << (15 - s);
    set_cfg(3);
    send_word(gen(20), 1'b1, "R7 carry over");
    send_word(gen(21), 1'b0, "R7 carry over");
    send_word(gen(22), 1'b1, "R7 carry over");
    send_word(gen(23), 1'b1, "R7 carry over");
    send_word(gen(24), 1'b0, "R7 carry over");
    send_word(gen(25), 1'b0, "R7 carry over");
    wait_idle();

    // R6: odd transfer mid-round
    set_cfg(2);
    send_word(gen(30), 1'b0, "R6 dangling dropped");
    send_byte(8'hA7, 1'b1);
    @(negedge clk_i);
    check(err_odd_o, "R6 odd transfer error", 32'(err_odd_o), 1);
    send_word(gen(31), 1'b0, "R6 dangling dropped");
    wait_idle();
    check(err_odd_o, "R6 error sticky", 32'(err_odd_o), 1);

    // R9: clear drops error, half byte and slot position
    do_clear();
    @(negedge clk_i);
    check(!err_odd_o, "R9 clear error", 32'(err_odd_o), 0);
    send_byte(8'h5C, 1'b0);
    do_clear();
    send_word(gen(40), 1'b0, "R9 half byte cleared");
    send_word(gen(41), 1'b0, "R9 half byte cleared");
    wait_idle();
    model_word(gen(42), "unused");
    send_byte(gen(42)[7:0], 1'b0);
    send_byte(gen(42)[15:8], 1'b0);
    do_clear();
    send_word(gen(43), 1'b0, "R9 slot cleared");
    send_word(gen(44), 1'b0, "R9 slot cleared");
    wait_idle();

    // R11: single channel and full width
    bmask[0] = 16'hFFFF;
    set_cfg(1);
    send_word(16'hA501, 1'b0, "R11 one channel");
    send_word(16'h0000, 1'b0, "R11 one channel");
    wait_idle();
    for (int s = 0; s < MS; s++) bmask[s] = W'(1) << s;
    set_cfg(16);
    for (int k = 0; k < 16; k++) send_word(gen(k + 50), 1'b0, "R11 sixteen channels");
    wait_idle();

    check(exp_q.size() == 0, "R4 all samples seen", 32'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule